// File: doc/BRIEF.md
# TDM Time-Space Switching Core

This block moves 8-bit channels between eight serial time-division input lines and eight serial output lines, each line carrying 32 channels per frame at two clock periods per bit. Every input line is deserialized and each completed channel byte is stored in a data memory indexed by line and channel. For every output slot, the block fetches a per-output connection word from a connection memory. That word either names one stored input byte, which is then switched in time and space, or carries a message byte that is sent unchanged in that slot every frame.

A control block reaches the connection memory through a single command channel. The channel uses valid/ready and carries a write flag, an address and write data. A command is taken when `cmd_valid` and `cmd_ready` are both high in a cycle. `cmd_ready` drops during the one cycle of each slot in which the output path fetches connection words. It also stays low while the initialization clear runs. A requester must hold its command stable until it is taken. Read data returns on a response pulse that has no back-pressure. The requester must accept it in the cycle it appears.

The output timebase runs a fixed two slots ahead of the input timebase. This gives room to finish an input byte before it is switched. Each serial output is modelled as a data bit plus a drive enable. While the enable is off, the line reads high.

Top module: `tdm_switch_core`

## Requirements
- R1: A rising edge on `frame_sync` makes the next cycle input count 0. The input count runs 0 to 511 and then wraps. The output count always equals the input count plus 32, modulo 512.
- R2: A bit cell spans two clocks. An input line is sampled on the second clock of each cell, which is an odd input count, most significant bit first. Channel s of line l occupies input counts 16s to 16s+15 and is stored at data address l*32+s.
- R3: When bit 8 of a connection word is 0, the output slot sends the data memory byte at word bits 7..0. Bits 7..5 select the input line and bits 4..0 select the input channel.
- R4: When bit 8 of a connection word is 1, the slot sends word bits 7..0. The same byte is sent again in every frame until the word is rewritten, whatever the input lines carry.
- R5: Initialization sets every connection word to 0x1FF, so an output channel that was never configured sends 0xFF.
- R6: After reset, `tx_en` is 0, `tx_data` is all ones and `cmd_ready` is 0. This lasts until the first frame boundary after a 32-cycle clear of the connection memory. `tx_en` becomes all ones one cycle after that boundary.
- R7: A command is accepted when `cmd_valid` and `cmd_ready` are both high. Outside initialization, `cmd_ready` is low exactly when the low four bits of the output count equal 14, and high otherwise. A held command waits and then takes effect. In `cmd_addr`, bits 7..5 give the output line and bits 4..0 give the output channel.
- R8: An accepted read raises `rsp_valid` for one cycle, in the next cycle, with the 9-bit word in `rsp_data`. `rsp_valid` is high at no other time.
- R9: Output slot t occupies output counts 16t to 16t+15, most significant bit first, and each bit is held for two clocks. `tx_data` is 1 on any line whose `tx_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, two periods per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset; starts initialization |
| frame_sync | input | 1 | Frame start on rising edge |
| rx_line | input | 8 | Serial input lines |
| tx_data | output | 8 | Serial output data, reads 1 when released |
| tx_en | output | 8 | Output drive enable per line |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = write connection word, 0 = read |
| cmd_addr | input | 8 | Output line (7..5) and channel (4..0) |
| cmd_wdata | input | 9 | Connection word to write |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_data | output | 9 | Connection word read back |

## Verification
A control-port access and the per-slot connection fetch can fall in the same cycle. The bench provokes this by issuing long runs of writes back to back. It also launches writes on purpose in the cycle where the fetch takes place. The bench judges the outcome in two ways. It checks that `cmd_ready` is low in exactly those fetch cycles and nowhere else. It also checks that every output byte sent in later frames matches a model built from the accepted writes, the input patterns and the fixed 32-count lead.

// File: rtl/tdmsw_pkg.sv
package tdmsw_pkg;
  localparam int DEF_LINES      = 8;
  localparam int DEF_CHANS      = 32;
  localparam int DEF_BITS       = 8;
  localparam int DEF_LEAD_SLOTS = 2;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RUN   = 2'd2
  } init_state_t;
endpackage

// File: rtl/tdmsw_timebase.sv
module tdmsw_timebase #(
  parameter int N_CHANS    = 32,
  parameter int CH_BITS    = 8,
  parameter int LEAD_SLOTS = 2,
  localparam int BIT_W  = $clog2(CH_BITS),
  localparam int CHAN_W = $clog2(N_CHANS),
  localparam int NIB_W  = BIT_W + 1,
  localparam int CNT_W  = CHAN_W + NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  output logic              rx_sample,
  output logic              rx_last,
  output logic [CHAN_W-1:0] rx_slot,
  output logic              fetch,
  output logic              load,
  output logic              shift,
  output logic [CHAN_W-1:0] fetch_slot,
  output logic              init_busy,
  output logic              clear_en,
  output logic [CHAN_W-1:0] clear_idx
);
  import tdmsw_pkg::*;

  localparam int FRAME_LEN = 1 << CNT_W;
  localparam int LEAD      = LEAD_SLOTS * CH_BITS * 2;
  localparam logic [NIB_W-1:0] FETCH_NIB = NIB_W'(2 * CH_BITS - 2);

  logic [CNT_W-1:0] in_cnt, out_cnt;
  logic             sync_q, rise, frame_end;
  init_state_t      state;
  logic [NIB_W-1:0] out_nib;

  assign rise      = frame_sync & ~sync_q;
  assign frame_end = rise | (in_cnt == CNT_W'(FRAME_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      in_cnt  <= '0;
      out_cnt <= CNT_W'(LEAD);
    end else begin
      sync_q  <= frame_sync;
      in_cnt  <= frame_end ? '0 : in_cnt + 1'b1;
      out_cnt <= frame_end ? CNT_W'(LEAD) : out_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CLEAR;
      clear_idx <= '0;
    end else begin
      case (state)
        ST_CLEAR: begin
          clear_idx <= clear_idx + 1'b1;
          if (clear_idx == CHAN_W'(N_CHANS - 1)) state <= ST_WAIT;
        end
        ST_WAIT: if (frame_end) state <= ST_RUN;
        default: state <= ST_RUN;
      endcase
    end
  end

  assign init_busy = (state != ST_RUN);
  assign clear_en  = (state == ST_CLEAR);

  assign rx_sample  = in_cnt[0];
  assign rx_last    = &in_cnt[NIB_W-1:0];
  assign rx_slot    = in_cnt[CNT_W-1:NIB_W];
  assign out_nib    = out_cnt[NIB_W-1:0];
  assign fetch      = (out_nib == FETCH_NIB);
  assign load       = &out_nib;
  assign shift      = out_nib[0] & ~load;
  assign fetch_slot = out_cnt[CNT_W-1:NIB_W] + 1'b1;

  // R1: a sync edge restarts the input count
  assert_sync_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (in_cnt == '0));
  // R1: the two counters stay a fixed lead apart
  assert_fixed_lead_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt == CNT_W'(in_cnt + CNT_W'(LEAD)));
  // R6: initialization ends only on a frame boundary
  assert_init_on_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_busy) |-> (in_cnt == '0));
endmodule

// File: rtl/tdmsw_rx.sv
module tdmsw_rx #(
  parameter int N_LINES = 8,
  parameter int N_CHANS = 32,
  parameter int CH_BITS = 8,
  localparam int CHAN_W = $clog2(N_CHANS),
  localparam int LINE_W = $clog2(N_LINES),
  localparam int ADDR_W = LINE_W + CHAN_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_LINES-1:0]               rx_line,
  input  logic                             sample,
  input  logic                             last,
  input  logic [CHAN_W-1:0]                wr_slot,
  input  logic [N_LINES-1:0][ADDR_W-1:0]   rd_addr,
  output logic [N_LINES-1:0][CH_BITS-1:0]  rd_data
);
  logic [N_LINES-1:0][CH_BITS-1:0] sh;
  logic [CH_BITS-1:0]              dm [N_LINES][N_CHANS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (sample) begin
      for (int l = 0; l < N_LINES; l++) sh[l] <= {sh[l][CH_BITS-2:0], rx_line[l]};
    end
  end

  always_ff @(posedge clk) begin
    if (sample && last) begin
      for (int l = 0; l < N_LINES; l++) dm[l][wr_slot] <= {sh[l][CH_BITS-2:0], rx_line[l]};
    end
  end

  for (genvar o = 0; o < N_LINES; o++) begin : g_rd
    assign rd_data[o] = dm[rd_addr[o][ADDR_W-1:CHAN_W]][rd_addr[o][CHAN_W-1:0]];
  end
endmodule

// File: rtl/tdmsw_cmem.sv
module tdmsw_cmem #(
  parameter int N_LINES = 8,
  parameter int N_CHANS = 32,
  parameter int CH_BITS = 8,
  localparam int CHAN_W = $clog2(N_CHANS),
  localparam int LINE_W = $clog2(N_LINES),
  localparam int ADDR_W = LINE_W + CHAN_W,
  localparam int WORD_W = CH_BITS + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            init_busy,
  input  logic                            clear_en,
  input  logic [CHAN_W-1:0]               clear_idx,
  input  logic                            fetch,
  input  logic [CHAN_W-1:0]               fetch_slot,
  input  logic                            cmd_valid,
  output logic                            cmd_ready,
  input  logic                            cmd_write,
  input  logic [ADDR_W-1:0]               cmd_addr,
  input  logic [WORD_W-1:0]               cmd_wdata,
  output logic                            rsp_valid,
  output logic [WORD_W-1:0]               rsp_data,
  output logic [N_LINES-1:0][WORD_W-1:0]  cm_q
);
  logic [WORD_W-1:0] cm [N_LINES][N_CHANS];
  logic              fire;
  logic [LINE_W-1:0] a_line;
  logic [CHAN_W-1:0] a_chan;

  assign cmd_ready = ~init_busy & ~fetch;
  assign fire      = cmd_valid & cmd_ready;
  assign a_line    = cmd_addr[ADDR_W-1:CHAN_W];
  assign a_chan    = cmd_addr[CHAN_W-1:0];

  always_ff @(posedge clk) begin
    if (clear_en) begin
      for (int l = 0; l < N_LINES; l++) cm[l][clear_idx] <= '1;
    end else if (fire && cmd_write) begin
      cm[a_line][a_chan] <= cmd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm_q      <= '1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (fetch) begin
        for (int l = 0; l < N_LINES; l++) cm_q[l] <= cm[l][fetch_slot];
      end
      rsp_valid <= fire & ~cmd_write;
      if (fire && !cmd_write) rsp_data <= cm[a_line][a_chan];
    end
  end

  // R6: the port is closed while the clear sweep runs
  assert_port_closed_in_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |-> !cmd_ready);
  // R8: every accepted read answers in the next cycle
  assert_read_answers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_write) |=> rsp_valid);
  // R8: no response without an accepted read
  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid && cmd_ready && !cmd_write));
endmodule

// File: rtl/tdmsw_tx.sv
module tdmsw_tx #(
  parameter int N_LINES = 8,
  parameter int CH_BITS = 8,
  parameter int ADDR_W  = 8,
  localparam int WORD_W = CH_BITS + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            init_busy,
  input  logic                            load,
  input  logic                            shift,
  input  logic [N_LINES-1:0][WORD_W-1:0]  cm_q,
  output logic [N_LINES-1:0][ADDR_W-1:0]  dm_addr,
  input  logic [N_LINES-1:0][CH_BITS-1:0] dm_data,
  output logic [N_LINES-1:0]              tx_data,
  output logic [N_LINES-1:0]              tx_en
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= ~init_busy;
  end

  assign tx_en = {N_LINES{en_q}};

  for (genvar o = 0; o < N_LINES; o++) begin : g_line
    logic [CH_BITS-1:0] sh;
    logic [CH_BITS-1:0] nxt;

    assign dm_addr[o] = cm_q[o][ADDR_W-1:0];
    assign nxt = cm_q[o][CH_BITS] ? cm_q[o][CH_BITS-1:0] : dm_data[o];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '1;
      else if (load)  sh <= nxt;
      else if (shift) sh <= {sh[CH_BITS-2:0], 1'b1};
    end

    assign tx_data[o] = en_q ? sh[CH_BITS-1] : 1'b1;
  end

  // R6: lines stay released for the whole initialization
  assert_released_in_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> ((tx_en == '0) && (&tx_data)));
endmodule

// File: rtl/tdm_switch_core.sv
module tdm_switch_core #(
  parameter int N_LINES    = tdmsw_pkg::DEF_LINES,
  parameter int N_CHANS    = tdmsw_pkg::DEF_CHANS,
  parameter int CH_BITS    = tdmsw_pkg::DEF_BITS,
  parameter int LEAD_SLOTS = tdmsw_pkg::DEF_LEAD_SLOTS,
  localparam int CHAN_W = $clog2(N_CHANS),
  localparam int LINE_W = $clog2(N_LINES),
  localparam int ADDR_W = LINE_W + CHAN_W,
  localparam int WORD_W = CH_BITS + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_sync,
  input  logic [N_LINES-1:0] rx_line,
  output logic [N_LINES-1:0] tx_data,
  output logic [N_LINES-1:0] tx_en,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_write,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [WORD_W-1:0]  cmd_wdata,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_data
);
  logic                            rx_sample, rx_last, fetch, load, shift;
  logic                            init_busy, clear_en;
  logic [CHAN_W-1:0]               rx_slot, fetch_slot, clear_idx;
  logic [N_LINES-1:0][WORD_W-1:0]  cm_q;
  logic [N_LINES-1:0][ADDR_W-1:0]  dm_addr;
  logic [N_LINES-1:0][CH_BITS-1:0] dm_data;

  tdmsw_timebase #(.N_CHANS(N_CHANS), .CH_BITS(CH_BITS), .LEAD_SLOTS(LEAD_SLOTS)) u_tb (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .rx_sample(rx_sample), .rx_last(rx_last), .rx_slot(rx_slot),
    .fetch(fetch), .load(load), .shift(shift), .fetch_slot(fetch_slot),
    .init_busy(init_busy), .clear_en(clear_en), .clear_idx(clear_idx)
  );

  tdmsw_rx #(.N_LINES(N_LINES), .N_CHANS(N_CHANS), .CH_BITS(CH_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .sample(rx_sample), .last(rx_last),
    .wr_slot(rx_slot), .rd_addr(dm_addr), .rd_data(dm_data)
  );

  tdmsw_cmem #(.N_LINES(N_LINES), .N_CHANS(N_CHANS), .CH_BITS(CH_BITS)) u_cm (
    .clk(clk), .rst_n(rst_n), .init_busy(init_busy), .clear_en(clear_en),
    .clear_idx(clear_idx), .fetch(fetch), .fetch_slot(fetch_slot),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .cm_q(cm_q)
  );

  tdmsw_tx #(.N_LINES(N_LINES), .CH_BITS(CH_BITS), .ADDR_W(ADDR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .init_busy(init_busy), .load(load), .shift(shift),
    .cm_q(cm_q), .dm_addr(dm_addr), .dm_data(dm_data),
    .tx_data(tx_data), .tx_en(tx_en)
  );
endmodule

// File: tb/tb_tdm_switch_core.sv
`timescale 1ns/1ps
module tb_tdm_switch_core;
  localparam int FR   = 512;
  localparam int LEAD = 32;

  logic       clk = 1'b0;
  logic       rst_n, frame_sync, cmd_valid, cmd_write;
  logic [7:0] rx_line, cmd_addr, tx_data, tx_en;
  logic [8:0] cmd_wdata, rsp_data;
  logic       cmd_ready, rsp_valid;

  logic [7:0] pat [8][32];
  logic [8:0] cmv [8][32];
  logic [7:0] col [8];
  int  k = 0, total = 0, bad = 0;
  bit  sync_prev = 0, check_on = 0, ready_mon = 0, done = 0;

  always #2.5 clk = ~clk;

  tdm_switch_core dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rx_line(rx_line),
    .tx_data(tx_data), .tx_en(tx_en), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h (k=%0d)", req, what, act, exp, k);
    end
  endtask

  function automatic logic [7:0] exp_byte(int l, int t);
    logic [8:0] w = cmv[l][t];
    return w[8] ? w[7:0] : pat[w[7:5]][w[4:0]];
  endfunction

  task automatic tick();
    bit r;
    int oc, nib, t;
    r = frame_sync && !sync_prev;
    sync_prev = frame_sync;
    @(posedge clk);
    k = r ? 0 : (k + 1) % FR;
    @(negedge clk);
    for (int l = 0; l < 8; l++) rx_line[l] = pat[l][k / 16][7 - ((k % 16) / 2)];
    oc = (k + LEAD) % FR; nib = oc % 16; t = oc / 16;
    if (nib % 2 == 0) for (int l = 0; l < 8; l++) col[l] = {col[l][6:0], tx_data[l]};
    if (nib == 14 && check_on) begin
      for (int l = 0; l < 8; l++) begin
        logic [7:0] e = exp_byte(l, t);
        if (cmv[l][t] == 9'h1FF)  chk(col[l] == e, "R5", "unconnected byte", col[l], e);
        else if (cmv[l][t][8])    chk(col[l] == e, "R4", "message byte", col[l], e);
        else                      chk(col[l] == e, "R3", "switched byte R9", col[l], e);
      end
    end
    if (ready_mon) chk(cmd_ready == (nib != 14), "R7", "ready vs fetch phase", cmd_ready, nib != 14);
  endtask

  task automatic wait_frames(int n);
    int c = 0;
    while (c < n) begin tick(); if (k == 0) c++; end
  endtask

  task automatic check_frame();
    wait_frames(1);
    check_on = 1;
    wait_frames(1);
    check_on = 0;
  endtask

  task automatic cm_write(int l, int t, logic [8:0] w);
    bit acc;
    cmd_valid = 1; cmd_write = 1; cmd_addr = {l[2:0], t[4:0]}; cmd_wdata = w;
    while (1) begin acc = cmd_ready; tick(); if (acc) break; end
    cmd_valid = 0;
    cmv[l][t] = w;
  endtask

  task automatic cm_read(int l, int t);
    bit acc;
    cmd_valid = 1; cmd_write = 0; cmd_addr = {l[2:0], t[4:0]};
    while (1) begin acc = cmd_ready; tick(); if (acc) break; end
    cmd_valid = 0;
    chk(rsp_valid == 1'b1, "R8", "rsp_valid after read", rsp_valid, 1);
    chk(rsp_data == cmv[l][t], "R8", "read word", rsp_data, cmv[l][t]);
    tick();
    chk(rsp_valid == 1'b0, "R8", "rsp_valid one cycle", rsp_valid, 0);
  endtask

  task automatic rand_pattern();
    for (int l = 0; l < 8; l++) for (int s = 0; s < 32; s++) pat[l][s] = 8'($urandom());
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rand_pattern();
    for (int l = 0; l < 8; l++) begin
      col[l] = 8'hFF;
      for (int t = 0; t < 32; t++) cmv[l][t] = 9'h1FF;
    end
    rst_n = 0; frame_sync = 0; cmd_valid = 0; cmd_write = 0; cmd_addr = 0;
    cmd_wdata = 0; rx_line = 0;
    repeat (4) @(negedge clk);
    chk(tx_en == 8'h00, "R6", "tx_en in reset", tx_en, 0);
    chk(tx_data == 8'hFF, "R6", "tx_data in reset", tx_data, 8'hFF);
    chk(cmd_ready == 1'b0, "R6", "ready in reset", cmd_ready, 0);
    chk(rsp_valid == 1'b0, "R8", "rsp idle", rsp_valid, 0);
    rst_n = 1;
    frame_sync = 1; tick(); frame_sync = 0;
    while (k != 100) tick();
    chk(cmd_ready == 1'b0, "R6", "ready during init", cmd_ready, 0);
    chk(tx_en == 8'h00, "R6", "tx_en during init", tx_en, 0);
    chk(tx_data == 8'hFF, "R6", "lines released during init", tx_data, 8'hFF);
    wait_frames(1);
    chk(tx_en == 8'h00, "R6", "tx_en at boundary", tx_en, 0);
    tick();
    chk(tx_en == 8'hFF, "R6", "tx_en after init", tx_en, 8'hFF);
    ready_mon = 1;

    // R5: nothing configured, every slot sends 0xFF
    wait_frames(2);
    check_frame();

    // R3 R4: random mix of switched, message and unconnected words (R2 input path)
    rand_pattern();
    for (int l = 0; l < 8; l++) for (int t = 0; t < 32; t++) begin
      int m = $urandom_range(0, 7);
      if (m < 2)       cm_write(l, t, {1'b1, 8'($urandom())});
      else if (m == 2) cm_write(l, t, 9'h1FF);
      else             cm_write(l, t, {1'b0, 8'($urandom())});
    end
    wait_frames(3);
    check_frame();

    // R4: message words repeat while inputs change
    rand_pattern();
    wait_frames(3);
    check_frame();

    // R3: corner addresses, broadcast from last and first input channel
    pat[7][31] = 8'hA5; pat[0][0] = 8'h01;
    for (int l = 0; l < 8; l++) for (int t = 0; t < 32; t++) begin
      if (t == 31)     cm_write(l, t, 9'h100);
      else if (t == 0) cm_write(l, t, 9'h17F);
      else if (t % 2)  cm_write(l, t, 9'h0FF);
      else             cm_write(l, t, 9'h000);
    end
    wait_frames(3);
    check_frame();

    // R1: resync in mid-frame, switching stays aligned afterwards
    while (k != 200) tick();
    frame_sync = 1; tick(); frame_sync = 0;
    chk(k == 0, "R1", "bench count after sync", k, 0);
    wait_frames(3);
    check_frame();

    // R7: write launched exactly in the fetch cycle waits one cycle
    while (((k + LEAD) % 16) != 14) tick();
    chk(cmd_ready == 1'b0, "R7", "ready in fetch cycle", cmd_ready, 0);
    cm_write(3, 9, 9'h1C3);
    cm_read(3, 9);

    // R8: random read-back
    for (int i = 0; i < 40; i++) cm_read($urandom_range(0, 7), $urandom_range(0, 31));
    wait_frames(2);
    check_frame();

    done = 1;
    summary();
    $finish;
  end
endmodule